// File: doc/BRIEF.md
# Video Color Plane Rearranger

This block sits in a pixel stream and rebuilds every output pixel from the color planes of the matching input pixel. Up to four output planes are produced. Each output plane takes either one chosen input plane or a constant padding value. The choice is fixed when the block is built, through one mapping code for each output plane. The same rearrangement is applied to every pixel lane when several pixels travel side by side in one beat. The stream uses a ready/valid handshake. Start-of-frame, end-of-line and last markers move through the block together with the data.

Software reaches a small register space on a simple write strobe / combinational read port. Padding values are first written into a staged copy. A commit arms them, and they take effect only on the first accepted beat of the next frame, so a frame never changes part way through. Two status bits let software see that writes are still waiting, and that a frame is in progress.

Top module: `plane_remap`

## Requirements
- R1: An output plane with mapping code 0 to 3 carries the input plane of that number from the same pixel lane, identically in every lane. Lane k, plane p sits at bits [(k*planes+p)*SYM_W +: SYM_W] on both streams.
- R2: An output plane with mapping code 4 carries the active padding value for that plane, cut to SYM_W bits.
- R3: Writes to the padding registers (byte address 0x148 + 4*plane) only update a staged copy, which reads back zero-extended and cut to SYM_W bits. The output does not change until a commit is followed by a frame start. A padding value has no effect on a plane whose code is not 4.
- R4: Writing 1 in bit 0 at address 0x144 while writes are pending makes the staged values active from the next accepted start-of-frame beat, including that beat itself. A commit made in the middle of a frame does not change that frame.
- R5: A commit made while no writes are pending is dropped. A padding write made after it needs a fresh commit.
- R6: Status bit 1 (address 0x140) reads 1 from the cycle after any padding write. It returns to 0 from the cycle after the start-of-frame beat that applies the committed values.
- R7: Status bit 0 reads 1 from the cycle after a start-of-frame beat is accepted, and 0 from the cycle after a beat with the last marker is accepted.
- R8: The output register updates one cycle after an input beat is accepted. Input ready is high when output ready is high or the output register is empty. A stalled output beat holds its data and markers.
- R9: The start-of-frame, end-of-line and last markers leave on the same output beat as the data they entered with.
- R10: Addresses 0x010, 0x014, 0x018 and 0x01C read the symbol width, pixels in parallel, input plane count and output plane count. Addresses 0x020 to 0x02C read the mapping codes of output planes 0 to 3.
- R11: Reserved addresses and the commit address read as zero. Writes to read-only or reserved addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | PIX_PAR*IN_PLANES*SYM_W | Input pixels, lane-major |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Block can accept a beat |
| inSof | input | 1 | Start-of-frame marker (user bit 0) |
| inEol | input | 1 | End-of-line marker |
| inLast | input | 1 | Last beat of the frame |
| outData | output | PIX_PAR*OUT_PLANES*SYM_W | Rearranged pixels |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream accepts the beat |
| outSof | output | 1 | Start-of-frame, aligned to outData |
| outEol | output | 1 | End-of-line, aligned to outData |
| outLast | output | 1 | Last marker, aligned to outData |
| csrAddr | input | 12 | Register byte address |
| csrWrite | input | 1 | Write strobe |
| csrWdata | input | 32 | Write data |
| csrRdata | output | 32 | Read data for csrAddr, combinational |

## Verification
Each accepted input beat shows up on the output one rising edge later. Status bits follow one edge after the write or accepted beat that moves them. Register reads are due in the same cycle the address is presented. A behavioural model in the bench moves on each rising edge with the same inputs the design sees. The bench then compares the outputs, the input ready and the markers with that model at the following falling edge, after all drives have settled. Padding timing is also checked directly: the bench captures the first and last output beats of each frame and compares their padded planes with constants. This shows that a commit touches only the next frame, and does change the start-of-frame beat itself.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ADDR_W   = 12;
  localparam int CODE_PAD = 4;

  localparam logic [ADDR_W-1:0] A_SYM_W    = 12'h010;
  localparam logic [ADDR_W-1:0] A_PIX_PAR  = 12'h014;
  localparam logic [ADDR_W-1:0] A_IN_N     = 12'h018;
  localparam logic [ADDR_W-1:0] A_OUT_N    = 12'h01C;
  localparam logic [ADDR_W-1:0] A_MAP_BASE = 12'h020;
  localparam logic [ADDR_W-1:0] A_STATUS   = 12'h140;
  localparam logic [ADDR_W-1:0] A_COMMIT   = 12'h144;
  localparam logic [ADDR_W-1:0] A_PAD_BASE = 12'h148;

  // control -> datapath
  typedef struct packed {
    logic loadPad;
  } ctrlCmd_t;

  // datapath -> control
  typedef struct packed {
    logic sofTaken;
    logic lastTaken;
  } dpEvt_t;
endpackage

// File: rtl/remap_dp.sv
module remap_dp
  import remap_pkg::*;
#(
  parameter int SYM_W      = 10,
  parameter int PIX_PAR    = 2,
  parameter int IN_PLANES  = 3,
  parameter int OUT_PLANES = 4,
  parameter int MAP0       = 2,
  parameter int MAP1       = 4,
  parameter int MAP2       = 0,
  parameter int MAP3       = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [PIX_PAR*IN_PLANES*SYM_W-1:0]  inData,
  input  logic                                inValid,
  output logic                                inReady,
  input  logic                                inSof,
  input  logic                                inEol,
  input  logic                                inLast,
  output logic [PIX_PAR*OUT_PLANES*SYM_W-1:0] outData,
  output logic                                outValid,
  input  logic                                outReady,
  output logic                                outSof,
  output logic                                outEol,
  output logic                                outLast,
  input  logic [SYM_W-1:0]                    shadowPad [OUT_PLANES],
  input  ctrlCmd_t                            cmd,
  output dpEvt_t                              evt
);
  localparam int MAPS [4] = '{MAP0, MAP1, MAP2, MAP3};
  localparam int OUT_W = PIX_PAR*OUT_PLANES*SYM_W;

  logic             validQ;
  logic             fire;
  logic             loadNow;
  logic [OUT_W-1:0] mapped;
  logic [SYM_W-1:0] activePad [OUT_PLANES];
  logic [SYM_W-1:0] padNow    [OUT_PLANES];

  assign inReady = outReady || !validQ;
  assign fire    = inValid && inReady;
  // committed values take effect on the start-of-frame beat itself
  assign loadNow = fire && inSof && cmd.loadPad;

  genvar o, k;
  generate
    for (o = 0; o < OUT_PLANES; o++) begin : g_plane
      assign padNow[o] = loadNow ? shadowPad[o] : activePad[o];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        activePad[o] <= '0;
        else if (loadNow) activePad[o] <= shadowPad[o];
      end

      for (k = 0; k < PIX_PAR; k++) begin : g_lane
        if (MAPS[o] < IN_PLANES) begin : g_sel
          assign mapped[(k*OUT_PLANES+o)*SYM_W +: SYM_W] =
            inData[(k*IN_PLANES+MAPS[o])*SYM_W +: SYM_W];
        end else begin : g_pad
          // code 4 (and any code beyond the input planes) emits padding
          assign mapped[(k*OUT_PLANES+o)*SYM_W +: SYM_W] = padNow[o];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      outData <= '0;
      outSof  <= 1'b0;
      outEol  <= 1'b0;
      outLast <= 1'b0;
    end else if (fire) begin
      validQ  <= 1'b1;
      outData <= mapped;
      outSof  <= inSof;
      outEol  <= inEol;
      outLast <= inLast;
    end else if (outReady) begin
      validQ  <= 1'b0;
    end
  end

  assign outValid = validQ;

  always_comb begin
    evt.sofTaken  = fire && inSof;
    evt.lastTaken = fire && inLast;
  end
endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int SYM_W      = 10,
  parameter int PIX_PAR    = 2,
  parameter int IN_PLANES  = 3,
  parameter int OUT_PLANES = 4,
  parameter int MAP0       = 2,
  parameter int MAP1       = 4,
  parameter int MAP2       = 0,
  parameter int MAP3       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWrite,
  input  logic [31:0]       csrWdata,
  output logic [31:0]       csrRdata,
  input  dpEvt_t            evt,
  output ctrlCmd_t          cmd,
  output logic [SYM_W-1:0]  shadowPad [OUT_PLANES],
  output logic              pendFlag,
  output logic              armFlag,
  output logic              busyFlag
);
  localparam int MAPS [4] = '{MAP0, MAP1, MAP2, MAP3};

  logic [OUT_PLANES-1:0] padHit;
  logic                  padAny;
  logic                  commitHit;
  logic                  pendQ, armQ, busyQ;

  genvar o;
  generate
    for (o = 0; o < OUT_PLANES; o++) begin : g_shadow
      assign padHit[o] = csrWrite && (csrAddr == A_PAD_BASE + ADDR_W'(4*o));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          shadowPad[o] <= '0;
        else if (padHit[o]) shadowPad[o] <= csrWdata[SYM_W-1:0];
      end
    end
    if (SYM_W < 32) begin : g_spare
      logic unusedWdata;
      assign unusedWdata = ^csrWdata[31:SYM_W];
    end
  endgenerate

  assign padAny    = |padHit;
  assign commitHit = csrWrite && (csrAddr == A_COMMIT) && csrWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      armQ  <= 1'b0;
      busyQ <= 1'b0;
    end else begin
      if (evt.sofTaken && armQ) begin
        armQ  <= 1'b0;
        pendQ <= 1'b0;
      end
      if (padAny)              pendQ <= 1'b1;
      // a commit with nothing staged is dropped
      if (commitHit && pendQ)  armQ  <= 1'b1;
      if (evt.lastTaken)       busyQ <= 1'b0;
      else if (evt.sofTaken)   busyQ <= 1'b1;
    end
  end

  assign cmd.loadPad = armQ;
  assign pendFlag    = pendQ;
  assign armFlag     = armQ;
  assign busyFlag    = busyQ;

  always_comb begin
    csrRdata = '0;
    case (csrAddr)
      A_SYM_W:   csrRdata = 32'(SYM_W);
      A_PIX_PAR: csrRdata = 32'(PIX_PAR);
      A_IN_N:    csrRdata = 32'(IN_PLANES);
      A_OUT_N:   csrRdata = 32'(OUT_PLANES);
      A_STATUS:  csrRdata = {30'd0, pendQ, busyQ};
      default:   csrRdata = '0;
    endcase
    for (int m = 0; m < 4; m++) begin
      if (csrAddr == A_MAP_BASE + ADDR_W'(4*m)) csrRdata = 32'(MAPS[m]);
    end
    for (int p = 0; p < OUT_PLANES; p++) begin
      if (csrAddr == A_PAD_BASE + ADDR_W'(4*p)) csrRdata = 32'(shadowPad[p]);
    end
  end
endmodule

// File: rtl/plane_remap.sv
module plane_remap
  import remap_pkg::*;
#(
  parameter int SYM_W      = 10,
  parameter int PIX_PAR    = 2,
  parameter int IN_PLANES  = 3,
  parameter int OUT_PLANES = 4,
  parameter int MAP0       = 2,
  parameter int MAP1       = 4,
  parameter int MAP2       = 0,
  parameter int MAP3       = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [PIX_PAR*IN_PLANES*SYM_W-1:0]  inData,
  input  logic                                inValid,
  output logic                                inReady,
  input  logic                                inSof,
  input  logic                                inEol,
  input  logic                                inLast,
  output logic [PIX_PAR*OUT_PLANES*SYM_W-1:0] outData,
  output logic                                outValid,
  input  logic                                outReady,
  output logic                                outSof,
  output logic                                outEol,
  output logic                                outLast,
  input  logic [11:0]                         csrAddr,
  input  logic                                csrWrite,
  input  logic [31:0]                         csrWdata,
  output logic [31:0]                         csrRdata
);
  localparam int OUT_W = PIX_PAR*OUT_PLANES*SYM_W;

  ctrlCmd_t         cmd;
  dpEvt_t           evt;
  logic [SYM_W-1:0] shadowPad [OUT_PLANES];
  logic             pendFlag, armFlag, busyFlag;

  remap_ctrl #(
    .SYM_W(SYM_W), .PIX_PAR(PIX_PAR), .IN_PLANES(IN_PLANES), .OUT_PLANES(OUT_PLANES),
    .MAP0(MAP0), .MAP1(MAP1), .MAP2(MAP2), .MAP3(MAP3)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .csrAddr(csrAddr), .csrWrite(csrWrite), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .evt(evt), .cmd(cmd), .shadowPad(shadowPad),
    .pendFlag(pendFlag), .armFlag(armFlag), .busyFlag(busyFlag)
  );

  remap_dp #(
    .SYM_W(SYM_W), .PIX_PAR(PIX_PAR), .IN_PLANES(IN_PLANES), .OUT_PLANES(OUT_PLANES),
    .MAP0(MAP0), .MAP1(MAP1), .MAP2(MAP2), .MAP3(MAP3)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .inSof(inSof), .inEol(inEol), .inLast(inLast),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .outSof(outSof), .outEol(outEol), .outLast(outLast),
    .shadowPad(shadowPad), .cmd(cmd), .evt(evt)
  );
endmodule

// File: rtl/plane_remap_chk.sv
module plane_remap_chk #(
  parameter int DATA_W = 80
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              inSof,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              outSof,
  input logic              outLast,
  input logic              sofTaken,
  input logic              pendFlag,
  input logic              armFlag,
  input logic              busyFlag
);
  assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outSof) && $stable(outLast));

  assert_accept_fills_R8: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  assert_sof_aligned_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outSof == $past(inSof));

  assert_pending_clears_on_sof_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendFlag) |-> $past(sofTaken && armFlag));

  assert_arm_needs_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armFlag) |-> $past(pendFlag));

  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyFlag) |-> $past(sofTaken));
endmodule

bind plane_remap plane_remap_chk #(.DATA_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .inValid(inValid), .inReady(inReady), .inSof(inSof),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outSof(outSof), .outLast(outLast),
  .sofTaken(evt.sofTaken), .pendFlag(pendFlag), .armFlag(armFlag), .busyFlag(busyFlag)
);

// File: tb/tb_plane_remap.sv
module tb_plane_remap;
  localparam int W   = 10;
  localparam int PP  = 2;
  localparam int NI  = 3;
  localparam int NO  = 4;
  localparam int MAPV [4] = '{2, 4, 0, 4};
  localparam int IW  = PP*NI*W;
  localparam int OW  = PP*NO*W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [IW-1:0] inData = '0;
  logic          inValid = 1'b0, inSof = 1'b0, inEol = 1'b0, inLast = 1'b0;
  logic          inReady;
  logic [OW-1:0] outData;
  logic          outValid, outSof, outEol, outLast;
  logic          outReady = 1'b1;
  logic [11:0]   csrAddr = '0;
  logic          csrWrite = 1'b0;
  logic [31:0]   csrWdata = '0;
  logic [31:0]   csrRdata;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  bit stallOn = 1'b0;

  always #10 clk = ~clk;

  plane_remap #(
    .SYM_W(W), .PIX_PAR(PP), .IN_PLANES(NI), .OUT_PLANES(NO),
    .MAP0(MAPV[0]), .MAP1(MAPV[1]), .MAP2(MAPV[2]), .MAP3(MAPV[3])
  ) dut (.*);

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] outPl(logic [OW-1:0] d, int k, int o);
    return d[(k*NO+o)*W +: W];
  endfunction
  function automatic logic [W-1:0] inPl(logic [IW-1:0] d, int k, int p);
    return d[(k*NI+p)*W +: W];
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [OW-1:0]   mData;
  logic            mValid, mSof, mEol, mLast, mPend, mArm, mBusy;
  logic [4*W-1:0]  mAct, mShadow;
  logic            mFire, mLd, mPendOld;

  function automatic logic [OW-1:0] buildPix(logic [IW-1:0] d, logic [4*W-1:0] pads);
    logic [OW-1:0] r = '0;
    for (int k = 0; k < PP; k++)
      for (int o = 0; o < NO; o++)
        if (MAPV[o] == 4) r[(k*NO+o)*W +: W] = pads[o*W +: W];
        else              r[(k*NO+o)*W +: W] = d[(k*NI+MAPV[o])*W +: W];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mData = '0; mValid = 0; mSof = 0; mEol = 0; mLast = 0;
      mPend = 0; mArm = 0; mBusy = 0; mAct = '0; mShadow = '0;
    end else begin
      mFire = inValid && (outReady || !mValid);
      mLd = mFire && inSof && mArm;
      mPendOld = mPend;
      if (mLd) mAct = mShadow;
      if (mFire) begin
        mData = buildPix(inData, mAct);
        mSof = inSof; mEol = inEol; mLast = inLast; mValid = 1;
        if (inLast) mBusy = 0;
        else if (inSof) mBusy = 1;
      end else if (outReady) mValid = 0;
      if (mLd) begin mArm = 0; mPend = 0; end
      if (csrWrite) begin
        for (int o = 0; o < NO; o++)
          if (csrAddr == 12'(12'h148 + 4*o)) begin
            mShadow[o*W +: W] = csrWdata[W-1:0];
            mPend = 1;
          end
        if (csrAddr == 12'h144 && csrWdata[0] && mPendOld) mArm = 1;
      end
    end
  end

  // per-cycle comparison at the falling edge, after drives settle
  logic [OW-1:0] sofPix, lastPix;
  always @(negedge clk) begin
    #3;
    if (rstN && checking) begin
      chk(outValid, mValid, "R8 outValid");
      chk(inReady, outReady || !mValid, "R8 inReady");
      if (mValid) begin
        chk(outData, mData, "R1 R2 outData");
        chk({outSof, outEol, outLast}, {mSof, mEol, mLast}, "R9 markers");
      end
      if (outValid && outReady && outSof)  sofPix  = outData;
      if (outValid && outReady && outLast) lastPix = outData;
    end
  end

  initial begin
    outReady = 1'b1;
    forever begin
      @(negedge clk);
      outReady = stallOn ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  // ---------------- drive tasks ----------------
  task automatic csrWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWrite = 1'b1;
    @(negedge clk);
    csrWrite = 1'b0;
  endtask

  task automatic csrRd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    csrAddr = a;
    #1;
    chk(csrRdata, exp, tag);
  endtask

  task automatic pushBeat(input logic [IW-1:0] d, input logic s, input logic e, input logic l);
    if (stallOn && ($urandom % 3 == 0)) begin
      @(negedge clk);
      inValid = 1'b0;
    end
    @(negedge clk);
    inData = d; inSof = s; inEol = e; inLast = l; inValid = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  logic [IW-1:0] firstIn;

  // midMode: 0 none, 1 status read, 2 padding write and commit mid-frame
  task automatic sendFrame(input int midMode, input logic [31:0] midStatus);
    for (int b = 0; b < 6; b++) begin
      logic [IW-1:0] d;
      d = IW'({$urandom, $urandom});
      if (b == 0) firstIn = d;
      pushBeat(d, b == 0, b % 3 == 2, b == 5);
      if (b == 2 && midMode == 1) csrRd(12'h140, midStatus, "R7 status mid-frame");
      if (b == 2 && midMode == 2) begin
        csrWr(12'h14C, 32'h2AA);
        csrWr(12'h144, 32'h1);
      end
    end
    do begin
      @(negedge clk);
      #4;
    end while (outValid);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checking = 1'b1;
    #4;
    chk(outValid, 1'b0, "R8 reset outValid");
    csrRd(12'h140, 32'h0, "R6 R7 status after reset");

    csrRd(12'h010, 32'd10, "R10 symbol width");
    csrRd(12'h014, 32'd2,  "R10 pixels in parallel");
    csrRd(12'h018, 32'd3,  "R10 input planes");
    csrRd(12'h01C, 32'd4,  "R10 output planes");
    csrRd(12'h020, 32'd2,  "R10 map plane 0");
    csrRd(12'h024, 32'd4,  "R10 map plane 1");
    csrRd(12'h028, 32'd0,  "R10 map plane 2");
    csrRd(12'h02C, 32'd4,  "R10 map plane 3");
    csrRd(12'h12C, 32'd0,  "R11 reserved read");
    csrRd(12'h144, 32'd0,  "R11 commit reads zero");

    // frame A: reset padding
    sendFrame(0, 0);
    chk(outPl(sofPix, 0, 1), 10'h0, "R2 pad plane 1 at reset");
    chk(outPl(sofPix, 1, 3), 10'h0, "R2 pad plane 3 at reset");
    chk(outPl(sofPix, 0, 0), inPl(firstIn, 0, 2), "R1 lane 0 plane 0 from input 2");
    chk(outPl(sofPix, 1, 2), inPl(firstIn, 1, 0), "R1 lane 1 plane 2 from input 0");

    // stage values
    csrWr(12'h14C, 32'h3AB);
    csrRd(12'h140, 32'h2, "R6 pending after write");
    csrWr(12'h154, 32'hFFF);
    csrWr(12'h148, 32'h123);
    csrRd(12'h154, 32'h3FF, "R3 staged readback cut to width");
    csrRd(12'h14C, 32'h3AB, "R3 staged readback");
    csrWr(12'h010, 32'h5);
    csrRd(12'h010, 32'd10, "R11 read-only write ignored");
    csrWr(12'h024, 32'h1);
    csrRd(12'h024, 32'd4, "R11 map write ignored");
    csrWr(12'h100, 32'hFFFF);
    csrRd(12'h100, 32'd0, "R11 reserved write ignored");
    csrRd(12'h140, 32'h2, "R11 status unchanged by ignored writes");

    // frame B: no commit, nothing changes
    sendFrame(0, 0);
    chk(outPl(sofPix, 0, 1), 10'h0, "R3 no effect without commit");
    csrRd(12'h140, 32'h2, "R6 pending held");

    // frame C: commit then frame with stalls
    csrWr(12'h144, 32'h1);
    stallOn = 1'b1;
    sendFrame(1, 32'h1);
    chk(outPl(sofPix, 0, 1), 10'h3AB, "R4 applied on start-of-frame beat");
    chk(outPl(sofPix, 1, 3), 10'h3FF, "R2 padding cut to width");
    chk(outPl(sofPix, 0, 0), inPl(firstIn, 0, 2), "R3 pad on mapped plane has no effect");
    csrRd(12'h140, 32'h0, "R6 R7 status after frame");

    // R5: commit with nothing pending is dropped
    csrWr(12'h144, 32'h1);
    csrWr(12'h14C, 32'h011);
    sendFrame(0, 0);
    chk(outPl(sofPix, 0, 1), 10'h3AB, "R5 stale commit dropped");
    csrRd(12'h140, 32'h2, "R5 still pending");
    csrWr(12'h144, 32'h1);
    sendFrame(0, 0);
    chk(outPl(sofPix, 1, 1), 10'h011, "R4 fresh commit applies");

    // mid-frame commit stays out of the current frame
    sendFrame(2, 0);
    chk(outPl(lastPix, 0, 1), 10'h011, "R4 no change inside frame");
    sendFrame(0, 0);
    chk(outPl(sofPix, 0, 1), 10'h2AA, "R4 applied at next frame");
    csrRd(12'h140, 32'h0, "R6 pending cleared");

    for (int f = 0; f < 4; f++) sendFrame(0, 0);
    stallOn = 1'b0;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule